// File: doc/BRIEF.md
# Maskable Interrupt Request Aggregator

This block gathers up to eight interrupt request lines from peripherals into one level-sensitive interrupt output for a processor. Peripherals set request bits by presenting a bit vector on a post input, and withdraw them with a bit vector on a clear input. Both take effect at the next clock edge. Software reaches the block through a byte-wide register port. There it programs an enable mask, reads the pending requests and acknowledges a line by writing its number.

The interrupt output is a registered level. It is high exactly when at least one pending request is also enabled. The primary mask port is inverted on the way in: a one written to a bit position disables that line, and a read returns the byte last written. A second, cascaded controller is present only as storage. Its mask byte can be written and read back, its status always reads as zero, and it never drives the interrupt. Reads have no side effects. The pending status can also be read as a 64-bit word.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the pending register and the enable mask are zero. `irqOut` is low, a byte read of the primary mask (address 0) returns 0xFF, and a byte read of the secondary mask (address 4) returns 0x00.
- R2: A write to address 0 stores the bitwise complement of `regWrData` as the enable mask, where bit i set enables line i. A later byte read of address 0 returns the written byte.
- R3: A byte read of address 1 returns the pending register in bits 7:0 with bits 63:8 zero. A read of address 1 with `regWide` high returns the pending register zero-extended to 64 bits.
- R4: A write to address 2 clears pending bit N, where N is `regWrData[3:0]`. Bits 7:4 of the written byte are ignored, and an N of 8 to 15 clears nothing.
- R5: Each set bit of `postVec` sets the matching pending bit at the next clock edge. Each set bit of `clearVec` clears it.
- R6: When a post coincides with a clear or an acknowledge of the same bit in one cycle, the bit ends up cleared.
- R7: `irqOut` is registered. At every edge it takes the OR of (pending AND enable) computed from the values that the same edge loads, so it changes one clock after the post, clear, acknowledge or mask write that caused the change.
- R8: A write to address 4 stores the byte as written, and a byte read of address 4 returns it. A read of address 5 returns zero. Writes to addresses 4, 5 and 6 never change `irqOut`, the pending register or the enable mask.
- R9: A read of address 2, 3, 6 or 7 returns zero. A read with `regWide` high at any address other than 1 returns zero. A write to address 1, 3 or 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWr | input | 1 | Register write strobe, one cycle per write |
| regRd | input | 1 | Register read strobe; read data is valid in the same cycle |
| regWide | input | 1 | Read is a 64-bit access instead of a byte access |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Write data byte |
| regRdData | output | 64 | Read data; zero when no read is selected |
| postVec | input | 8 | Peripheral request set vector |
| clearVec | input | 8 | Peripheral request clear vector |
| irqOut | output | 1 | Combined interrupt request level |

## Verification
A wrong pending bit or a wrong enable bit appears on `irqOut` at the first edge where the other operand of the AND selects that line. It also appears at once on a read of address 1 or address 0. For this reason the bench reads both registers right after each class of update, so a corrupted bit never goes unseen for more than a cycle or two. A lost or inverted mask complement appears as a read-back mismatch in the same cycle as the read. An acknowledge that decodes the wrong bit appears as a pending bit that survives, or a neighbouring bit that vanishes, on the next status read.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int ADDR_W = 3;

  // Register addresses; ports 0..2 belong to the primary controller, 4..6 to the cascaded one
  typedef enum logic [ADDR_W-1:0] {
    ADR_PRI_MASK = 3'd0,
    ADR_PRI_STAT = 3'd1,
    ADR_PRI_ACK  = 3'd2,
    ADR_SEC_MASK = 3'd4,
    ADR_SEC_STAT = 3'd5,
    ADR_SEC_ACK  = 3'd6
  } regAddrE;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_PRI_MASK,
    RD_PRI_STAT,
    RD_SEC_MASK
  } rdSelE;

  typedef struct packed {
    logic  priMaskWr;
    logic  secMaskWr;
    logic  ackWr;
    rdSelE rdSel;
  } ctrlStrobeT;

endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
(
  input  logic              regWr,
  input  logic              regRd,
  input  logic              regWide,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobeT        strb
);

  always_comb begin
    strb = '{priMaskWr: 1'b0, secMaskWr: 1'b0, ackWr: 1'b0, rdSel: RD_NONE};
    if (regWr) begin
      case (regAddr)
        ADR_PRI_MASK: strb.priMaskWr = 1'b1;
        ADR_PRI_ACK:  strb.ackWr     = 1'b1;
        ADR_SEC_MASK: strb.secMaskWr = 1'b1;
        default:      ;
      endcase
    end
    if (regRd) begin
      case (regAddr)
        ADR_PRI_MASK: strb.rdSel = regWide ? RD_NONE : RD_PRI_MASK;
        ADR_PRI_STAT: strb.rdSel = RD_PRI_STAT;
        ADR_SEC_MASK: strb.rdSel = regWide ? RD_NONE : RD_SEC_MASK;
        default:      strb.rdSel = RD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/irq_agg_dp.sv
module irq_agg_dp
  import irq_agg_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DATA_W    = 8,
  parameter int RDATA_W   = 64,
  parameter int ACK_W     = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobeT           strb,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [NUM_LINES-1:0] postVec,
  input  logic [NUM_LINES-1:0] clearVec,
  output logic [RDATA_W-1:0]   rdData,
  output logic                 irqOut
);

  logic [NUM_LINES-1:0] pendQ, pendNext;
  logic [NUM_LINES-1:0] enQ, enNext;
  logic [DATA_W-1:0]    secMaskQ, secMaskNext;
  logic [NUM_LINES-1:0] ackHit;
  logic [ACK_W-1:0]     ackIdx;
  logic                 irqQ;

  assign ackIdx = wrData[ACK_W-1:0];

  // One comparator per line; an index past the last line matches none
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_ack
    assign ackHit[i] = strb.ackWr && (ackIdx == ACK_W'(i));
  end

  // Clears and acknowledges win over a post to the same bit
  assign pendNext    = (pendQ | postVec) & ~clearVec & ~ackHit;
  assign enNext      = strb.priMaskWr ? ~wrData[NUM_LINES-1:0] : enQ;
  assign secMaskNext = strb.secMaskWr ? wrData : secMaskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ    <= '0;
      enQ      <= '0;
      secMaskQ <= '0;
      irqQ     <= 1'b0;
    end else begin
      pendQ    <= pendNext;
      enQ      <= enNext;
      secMaskQ <= secMaskNext;
      irqQ     <= |(pendNext & enNext);
    end
  end

  assign irqOut = irqQ;

  always_comb begin
    rdData = '0;
    case (strb.rdSel)
      RD_PRI_MASK: rdData[NUM_LINES-1:0] = ~enQ;
      RD_PRI_STAT: rdData[NUM_LINES-1:0] = pendQ;
      RD_SEC_MASK: rdData[DATA_W-1:0]    = secMaskQ;
      default:     rdData = '0;
    endcase
  end

  // R7: output level agrees with the stored pending and enable registers
  a_r7_irq_level: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == |(pendQ & enQ));

  // R2: a primary mask write loads the complement of the written byte
  a_r2_mask_complement: assert property (@(posedge clk) disable iff (!rstN)
    strb.priMaskWr |=> (enQ == ~$past(wrData[NUM_LINES-1:0])));

  // R6: a cleared or acknowledged bit is low after the edge, even if posted
  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendQ & ($past(clearVec) | $past(ackHit))) == '0));

  // R5: a post not cancelled in the same cycle leaves its bit set
  a_r5_post_sets: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendQ & $past(postVec & ~clearVec & ~ackHit))
              == $past(postVec & ~clearVec & ~ackHit)));

  // R8: the secondary mask register holds when not written
  a_r8_sec_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.secMaskWr |=> $stable(secMaskQ));

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DATA_W    = 8,
  parameter int RDATA_W   = 64,
  parameter int ACK_W     = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWr,
  input  logic                 regRd,
  input  logic                 regWide,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [RDATA_W-1:0]   regRdData,
  input  logic [NUM_LINES-1:0] postVec,
  input  logic [NUM_LINES-1:0] clearVec,
  output logic                 irqOut
);

  ctrlStrobeT strb;

  irq_agg_ctrl i_ctrl (
    .regWr   (regWr),
    .regRd   (regRd),
    .regWide (regWide),
    .regAddr (regAddr),
    .strb    (strb)
  );

  irq_agg_dp #(
    .NUM_LINES (NUM_LINES),
    .DATA_W    (DATA_W),
    .RDATA_W   (RDATA_W),
    .ACK_W     (ACK_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (regWrData),
    .postVec  (postVec),
    .clearVec (clearVec),
    .rdData   (regRdData),
    .irqOut   (irqOut)
  );

  // R8: the cascaded controller's status port always reads zero
  a_r8_sec_stat_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == ADR_SEC_STAT) |-> (regRdData == '0));

  // R9: no data is returned without a read strobe
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !regRd |-> (regRdData == '0));

endmodule

// File: tb/test_irq_aggregator.sv
`timescale 1ns/1ps
module test_irq_aggregator;

  localparam real CLK_NS = 4.0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0, regRd = 1'b0, regWide = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [63:0] regRdData;
  logic [7:0]  postVec = '0, clearVec = '0;
  logic        irqOut;

  int checks = 0;
  int errors = 0;

  // Behavioural reference state
  logic [7:0] refPend = '0, refEn = '0, refSec = '0;
  logic       refIrq = 1'b0;

  always #(CLK_NS / 2.0) clk = ~clk;

  irq_aggregator i_irq_aggregator (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regWide(regWide),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .postVec(postVec), .clearVec(clearVec), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] expRead(input logic [2:0] a, input logic wide);
    if (wide) return (a == 3'd1) ? {56'd0, refPend} : 64'd0;
    case (a)
      3'd0: return {56'd0, ~refEn};
      3'd1: return {56'd0, refPend};
      3'd4: return {56'd0, refSec};
      default: return 64'd0;
    endcase
  endfunction

  // One clock: drive, check read data before the edge, update model, check irq after it
  task automatic cyc(input string tag, input logic wr, input logic rd, input logic wide,
                     input logic [2:0] a, input logic [7:0] d,
                     input logic [7:0] p, input logic [7:0] c);
    logic [7:0] ack;
    @(negedge clk);
    regWr = wr; regRd = rd; regWide = wide; regAddr = a; regWrData = d;
    postVec = p; clearVec = c;
    #1;
    if (rd) check({tag, " read"}, regRdData, expRead(a, wide));
    ack = (wr && a == 3'd2 && d[3:0] < 4'd8) ? (8'd1 << d[3:0]) : 8'd0;
    @(posedge clk);
    refPend = (refPend | p) & ~c & ~ack;
    if (wr && a == 3'd0) refEn = ~d;
    if (wr && a == 3'd4) refSec = d;
    refIrq = |(refPend & refEn);
    #1;
    check({tag, " irq"}, {63'd0, irqOut}, {63'd0, refIrq});
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic wide);
    cyc(tag, 1'b0, 1'b1, wide, a, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic wr(input string tag, input logic [2:0] a, input logic [7:0] d);
    cyc(tag, 1'b1, 1'b0, 1'b0, a, d, 8'h00, 8'h00);
  endtask

  task automatic pc(input string tag, input logic [7:0] p, input logic [7:0] c);
    cyc(tag, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00, p, c);
  endtask

  initial begin
    #(CLK_NS * 200000.0);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 irq after reset", {63'd0, irqOut}, 64'd0);
    rd("R1 primary mask", 3'd0, 1'b0);
    rd("R1 primary status", 3'd1, 1'b0);
    rd("R1 secondary mask", 3'd4, 1'b0);

    // R5 posts with everything disabled: no irq
    pc("R5 post 0x05", 8'h05, 8'h00);
    rd("R5 status after post", 3'd1, 1'b0);
    // R2 mask complement, R7 irq rises one clock later
    wr("R2 enable line 2", 3'd0, 8'hFB);
    rd("R2 mask readback", 3'd0, 1'b0);
    rd("R7 irq held", 3'd1, 1'b0);
    // R3 wide status read
    pc("R3 post 0x80", 8'h80, 8'h00);
    rd("R3 wide status", 3'd1, 1'b1);
    rd("R3 byte status", 3'd1, 1'b0);
    // R4 acknowledge
    wr("R4 ack line 2", 3'd2, 8'h02);
    rd("R4 status after ack", 3'd1, 1'b0);
    wr("R4 ack index 9 ignored", 3'd2, 8'h09);
    rd("R4 status after index 9", 3'd1, 1'b0);
    wr("R4 ack 0x17 upper nibble ignored", 3'd2, 8'h17);
    rd("R4 status after 0x17", 3'd1, 1'b0);
    // R5 clear
    pc("R5 post 0x3C", 8'h3C, 8'h00);
    wr("R7 enable all", 3'd0, 8'h00);
    pc("R5 clear 0x0C", 8'h00, 8'h0C);
    rd("R5 status after clear", 3'd1, 1'b0);
    pc("R7 clear remaining", 8'h00, 8'hFF);
    // R6 post vs clear and ack in same cycle
    pc("R6 post and clear bit 4", 8'h11, 8'h10);
    rd("R6 status", 3'd1, 1'b0);
    cyc("R6 post and ack bit 6", 1'b1, 1'b0, 1'b0, 3'd2, 8'h06, 8'h40, 8'h00);
    rd("R6 status after ack race", 3'd1, 1'b0);
    // R7 mask changes drive irq
    wr("R7 disable line 0", 3'd0, 8'h01);
    wr("R7 enable line 0", 3'd0, 8'hFE);
    // R8 secondary controller
    wr("R8 secondary mask", 3'd4, 8'hA5);
    rd("R8 secondary mask readback", 3'd4, 1'b0);
    rd("R8 secondary status", 3'd5, 1'b0);
    wr("R8 secondary ack", 3'd6, 8'h00);
    wr("R8 secondary status write", 3'd5, 8'hFF);
    rd("R8 primary status unchanged", 3'd1, 1'b0);
    rd("R8 primary mask unchanged", 3'd0, 1'b0);
    // R9 unmapped and wrong-size reads, writes that change nothing
    rd("R9 read ack port", 3'd2, 1'b0);
    rd("R9 read addr 7", 3'd7, 1'b0);
    rd("R9 wide mask read", 3'd0, 1'b1);
    rd("R9 wide secondary read", 3'd4, 1'b1);
    wr("R9 write status port", 3'd1, 8'hFF);
    wr("R9 write addr 3", 3'd3, 8'h00);
    wr("R9 write addr 7", 3'd7, 8'h00);
    rd("R9 status after ignored writes", 3'd1, 1'b0);
    rd("R9 mask after ignored writes", 3'd0, 1'b0);
    // Sweep: post each line, ack it, irq follows every step
    for (int i = 0; i < 8; i++) begin
      wr("R2 sweep mask", 3'd0, ~(8'd1 << i));
      pc("R5 sweep post", 8'd1 << i, 8'h00);
      rd("R3 sweep status", 3'd1, 1'b0);
      wr("R4 sweep ack", 3'd2, 8'(i));
      rd("R4 sweep status", 3'd1, 1'b0);
    end
    pc("R7 idle", 8'h00, 8'h00);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule